// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product. N defaults to 32. It is a multi-cycle unit. A one-cycle start pulse captures both operands. The block then runs one recoding step per clock. A one-cycle done pulse marks the cycle in which the product output first holds the final result.

The datapath uses one 2N-bit working register and one extra flag bit, the "previous bit". The upper half of the register collects the partial result, and the lower half starts out holding the multiplier. On each step the recoder looks at the lowest multiplier bit and the previous bit. The multiplicand is then added to or subtracted from the upper half, or the upper half is left as it is. After that, the whole register and the flag shift one place right with the sign bit copied in. Operands with either sign need no extra correction pass at the end.

The product stays on the output until the next accepted start. A start that arrives while a computation is running has no effect.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy and done are 0 and product is all zeros.
- R2: A start is accepted on the rising edge where start is sampled high and busy is low. Done is then 1 in exactly the cycle that follows the N-th rising edge after that edge, and it is 0 again one cycle later.
- R3: When done is 1, product equals the two's-complement product of the captured multiplicand and multiplier, sign-extended to 2N bits, for every sign combination. The pair {lowest multiplier bit, previous bit} is recoded as follows: 10 subtracts the multiplicand, 01 adds it, 00 and 11 leave the upper half unchanged.
- R4: Operands at the most negative value (1 followed by N-1 zeros) give exact results. Most negative times most negative is 2^(2N-2), and most negative times -1 is +2^(N-1) in 2N bits.
- R5: Busy is 1 from the cycle after an accepted start until the cycle in which done rises. Busy and done are never 1 in the same cycle.
- R6: A start pulse while busy is 1 leaves the running operation unchanged: the latency and the product are those of the original operands.
- R7: While busy is 0 and no start is accepted, product holds its value.
- R8: A start sampled in the same cycle that done is 1 is accepted. A new computation begins with the same latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that captures the operands when the block is idle |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse, product valid |
| product | output | 2N | Signed 2N-bit product |

## Verification
Small positive pairs exercise the add and subtract steps on their own. Mixed-sign and negative-negative pairs show whether the arithmetic shift copies the sign correctly. Alternating bit patterns in the multiplier force a subtract or add on every step, and all-ones or all-zeros multipliers force a long run of no-op steps. Between them, these cases separate a wrong recoding of the bit pair from a wrong shift. The most negative operands push the adder past N bits and so show whether the extra intermediate bit is kept. Extra start pulses during a run and a start in the done cycle test the handshake.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2
    } booth_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_ctl_t;

    // Radix-2 recoding of {current multiplier bit, previous bit}
    function automatic booth_op_e booth_recode(input logic cur, input logic prev);
        booth_op_e op;
        unique case ({cur, prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_NOP;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    always_comb begin
        op = booth_recode(cur_bit, prev_bit);
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N:0]   result
);
    localparam int W = N + 1;

    logic [W-1:0] acc_x;
    logic [W-1:0] mc_x;

    // Sign-extend both sides so the sum never overflows W bits
    assign acc_x = {acc[N-1], acc};
    assign mc_x  = {mcand[N-1], mcand};

    always_comb begin
        unique case (op)
            OP_ADD:  result = acc_x + mc_x;
            OP_SUB:  result = acc_x - mc_x;
            default: result = acc_x;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output seq_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int          CW   = $clog2(N) + 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        ctl.load = start && (state_q == ST_IDLE);
        ctl.step = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ctl.load) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (ctl.step) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = done_q;
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    seq_ctl_t  ctl;
    booth_op_e op;
    logic [N-1:0] acc_q;   // upper half: partial result
    logic [N-1:0] mq_q;    // lower half: remaining multiplier bits
    logic [N-1:0] mc_q;    // captured multiplicand
    logic         prev_q;  // extra low-order bit
    logic [N:0]   sum;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    booth_recoder u_rec (
        .cur_bit  (mq_q[0]),
        .prev_bit (prev_q),
        .op       (op)
    );

    booth_addsub #(.N(N)) u_as (
        .acc    (acc_q),
        .mcand  (mc_q),
        .op     (op),
        .result (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mq_q   <= '0;
            mc_q   <= '0;
            prev_q <= 1'b0;
        end else if (ctl.load) begin
            acc_q  <= '0;
            mq_q   <= mplier;
            mc_q   <= mcand;
            prev_q <= 1'b0;
        end else if (ctl.step) begin
            // arithmetic right shift of {sum, mq, prev}
            acc_q  <= sum[N:1];
            mq_q   <= {sum[0], mq_q[N-1:1]};
            prev_q <= mq_q[0];
        end
    end

    assign product = {acc_q, mq_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int CW = $clog2(N) + 2;

    logic [CW-1:0]  steps_q;
    logic [N-1:0]   a_q, b_q;
    logic [2*N-1:0] ref_prod;
    logic           min_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            steps_q <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else if (start && !busy) begin
            steps_q <= '0;
            a_q     <= mcand;
            b_q     <= mplier;
        end else if (busy) begin
            steps_q <= steps_q + 1'b1;
        end
    end

    assign ref_prod = {{N{a_q[N-1]}}, a_q} * {{N{b_q[N-1]}}, b_q};
    assign min_pair = (a_q == {1'b1, {(N-1){1'b0}}}) && (b_q == {1'b1, {(N-1){1'b0}}});

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (steps_q == CW'(N)));

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_product_value: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_prod));

    a_r4_min_square: assert property (@(posedge clk) disable iff (rst)
        (done && min_pair) |-> (product == ({{(2*N-1){1'b0}}, 1'b1} << (2*N-2))));

    a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && steps_q < CW'(N - 1)) |=> (busy && $stable(a_q) && $stable(b_q)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    a_r8_start_on_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> busy);
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;
    localparam int N  = 32;
    localparam int WD = 200000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    booth_seq_mult #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return {{N{a[N-1]}}, a} * {{N{b[N-1]}}, b};
    endfunction

    task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Waits at negedges for done; returns edges counted after the accept edge
    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < N + 8) begin
            @(negedge clk);
            k = k + 1;
        end
    endtask

    // Drive start at a negedge; the following posedge accepts it
    task automatic pulse_start(input logic [N-1:0] a, input logic [N-1:0] b);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy", {63'd0, busy}, '0);
        check("R1 done", {63'd0, done}, '0);
        check("R1 product", product, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {62'd0, busy, done}, '0);
    endtask

    task automatic t_mul(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
        int k;
        logic [2*N-1:0] held;
        pulse_start(a, b);
        check({req, " R5 busy during run"}, {63'd0, busy}, 64'd1);
        wait_done(k);
        check({req, " R2 latency"}, 64'(k), 64'(N));
        check({req, " product"}, product, ref_mul(a, b));
        check({req, " R5 busy low at done"}, {63'd0, busy}, '0);
        held = product;
        mcand = ~a; mplier = ~b;
        @(negedge clk);
        check({req, " R2 done single cycle"}, {63'd0, done}, '0);
        repeat (3) @(negedge clk);
        check({req, " R7 product holds"}, product, held);
    endtask

    task automatic t_busy_start();
        int k;
        logic [N-1:0] a = 32'h0000_1234;
        logic [N-1:0] b = 32'hFFFF_F00D;
        pulse_start(a, b);
        repeat (5) @(negedge clk);
        mcand = 32'h7FFF_FFFF; mplier = 32'h7FFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(k);
        check("R6 latency unchanged", 64'(k + 6), 64'(N));
        check("R6 product of first operands", product, ref_mul(a, b));
        @(negedge clk);
        check("R6 no restart", {63'd0, busy}, '0);
    endtask

    task automatic t_back_to_back();
        int k;
        logic [N-1:0] a2 = 32'hDEAD_BEEF;
        logic [N-1:0] b2 = 32'h0BAD_F00D;
        pulse_start(32'd7, 32'hFFFF_FFF9);
        wait_done(k);
        check("R8 first product", product, ref_mul(32'd7, 32'hFFFF_FFF9));
        pulse_start(a2, b2);
        check("R8 accepted in done cycle", {63'd0, busy}, 64'd1);
        wait_done(k);
        check("R8 latency", 64'(k), 64'(N));
        check("R8 second product", product, ref_mul(a2, b2));
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_mul("R3 pos*pos", 32'd2, 32'd6);
        t_mul("R3 pos*neg", 32'd2, 32'hFFFF_FFFD);
        t_mul("R3 neg*pos", 32'hFFFF_FFF8, 32'd12345);
        t_mul("R3 neg*neg", 32'hFFFF_FFF8, 32'hFFFF_FFF8);
        t_mul("R3 alternating", 32'h5555_5555, 32'hAAAA_AAAA);
        t_mul("R3 ones multiplier", 32'h1357_9BDF, 32'hFFFF_FFFF);
        t_mul("R3 zero multiplier", 32'h89AB_CDEF, 32'd0);
        t_mul("R3 zero multiplicand", 32'd0, 32'h8000_0001);
        t_mul("R4 min*min", 32'h8000_0000, 32'h8000_0000);
        check("R4 min*min value", product, 64'h4000_0000_0000_0000);
        t_mul("R4 min*-1", 32'h8000_0000, 32'hFFFF_FFFF);
        check("R4 min*-1 value", product, 64'h0000_0000_8000_0000);
        t_mul("R4 max*min", 32'h7FFF_FFFF, 32'h8000_0000);
        t_busy_start();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule